// File: doc/BRIEF.md
# Feedback-Locked Two-Phase Clock Generator

This block makes two clocks at one shared frequency from a tick that runs at half the rate of its input clock. The first clock always has a 50% duty cycle. The second clock is placed by an 8-bit phase setting and an 8-bit duty setting, both taken as fractions of the current period. The period, counted in ticks, starts at 240. With a 48 MHz input this gives 100 kHz.

The active-high feedback input is expected to pulse once per period, inside the low half of the 50% clock. In each period the generator measures how far the first rising feedback edge lies from the centre of that low half, in ticks. Later edges in the same period are ignored, so chatter on the feedback line has no effect. The signed error goes through a single-pole IIR low-pass filter whose time constant is a power of two selected by a shift setting. Half of the filtered error, in whole ticks, is added to the nominal period. The result is clamped to a programmable tick range and takes effect at the next period boundary. The period in use is available as a readback.

Top module: `fb_clk_gen`

## Requirements
- R1: While rst_ni is low and directly after reset is released, period_o is 240, clk50_o is 1 and clk_ph_o is 0.
- R2: An internal tick occurs on every second rising edge of clk_i, and the first tick comes on the second edge after reset. A tick counter c runs from 0 to P-1, where P is period_o. One output period therefore lasts 2·P clk_i cycles.
- R3: clk50_o is 1 while c < floor(P/2) and 0 for the rest of the period.
- R4: Let s = floor(phase_i·P/256) and w = floor(duty_i·P/256). clk_ph_o is 1 exactly when ((c − s) mod P) < w, so it stays 0 when duty_i is 0.
- R5: fb_i passes through two synchronising flops, and the synchronised value is sampled on each tick. A rising edge is a sample of 1 that follows a sample of 0. Its error is c − m, where m = floor(P/2) + floor((P − floor(P/2))/2).
- R6: Only the first rising edge in a period sets that period's error. Further edges in the same period are ignored. A period with no edge has error 0.
- R7: On the last tick of a period (c = P−1), a filter state y (reset 0) is updated as y ← y + floor((e·256 − y) / 2^k), where e is that period's error and k is tc_shift_i.
- R8: On the same tick the next period becomes 240 + floor(y/512), using the updated y. This value is raised to per_min_i if below it, then lowered to per_max_i if above it, then raised to 4 if below 4. The period changes at no other time.
- R9: With fb_i held low, period_o stays at 240.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock (48 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fb_i | input | 1 | Feedback pulse, active high, asynchronous |
| tc_shift_i | input | 4 | Filter shift k, time constant about 2^k periods |
| per_min_i | input | 10 | Lower period clamp, in ticks |
| per_max_i | input | 10 | Upper period clamp, in ticks |
| phase_i | input | 8 | Phase offset of clk_ph_o, in 1/256 of a period |
| duty_i | input | 8 | High time of clk_ph_o, in 1/256 of a period |
| clk50_o | output | 1 | 50% duty output clock |
| clk_ph_o | output | 1 | Phase and duty programmable output clock |
| period_o | output | 10 | Period in use, in ticks |

## Verification
A wrong tick counter or period register shows at once on clk50_o and clk_ph_o, within one input cycle, because both outputs are derived from that state on every edge. A fault in the filter state or in the edge capture stays hidden until the end of the period in which it occurs. It then appears as a period_o value that differs from the reference, and this happens in the first period where the filtered error crosses a 512 boundary. The reference model is compared with all three outputs on every input cycle. The runs cover idle operation, locking, clamping, the floor of 4, chatter on the feedback input and extreme phase and duty settings.

// File: rtl/fbclk_pkg.sv
package fbclk_pkg;
  localparam int unsigned FRAC_BITS = 8;  // filter state fraction
  localparam int unsigned GAIN_SHR  = 1;  // period steer = y / 2^(FRAC+GAIN)
  localparam int unsigned PER_FLOOR = 4;
endpackage

// File: rtl/fb_clk_div.sv
module fb_clk_div #(
  parameter int unsigned PW = 10,
  parameter int unsigned CW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic [PW-1:0] per_i,
  input  logic [PW-1:0] per_nxt_i,
  input  logic [CW-1:0] phase_i,
  input  logic [CW-1:0] duty_i,
  output logic [PW-1:0] cnt_o,
  output logic          last_o,
  output logic          clk50_o,
  output logic          clk_ph_o
);
  localparam int unsigned MW = PW + CW;

  logic [PW-1:0] cnt_q, cnt_n;

  function automatic logic ph_level(input logic [PW-1:0] c, input logic [PW-1:0] p,
                                    input logic [CW-1:0] ph, input logic [CW-1:0] du);
    logic [MW-1:0] sp, wp;
    logic [PW-1:0] s, w, d;
    sp = MW'(ph) * MW'(p);
    wp = MW'(du) * MW'(p);
    s  = sp[MW-1:CW];
    w  = wp[MW-1:CW];
    d  = (c >= s) ? c - s : c + p - s;
    return d < w;
  endfunction

  assign last_o = tick_i && (cnt_q == per_i - 1'b1);
  assign cnt_n  = !tick_i ? cnt_q : (last_o ? '0 : cnt_q + 1'b1);
  assign cnt_o  = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q    <= '0;
      clk50_o  <= 1'b1;
      clk_ph_o <= 1'b0;
    end else begin
      cnt_q    <= cnt_n;
      clk50_o  <= cnt_n < (per_nxt_i >> 1);
      clk_ph_o <= ph_level(cnt_n, per_nxt_i, phase_i, duty_i);
    end
  end

  // R2
  cnt_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni) cnt_q < per_i);
  // R3
  c50_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(clk50_o) |-> cnt_q == '0);
endmodule

// File: rtl/fb_phase_det.sv
module fb_phase_det #(
  parameter int unsigned PW = 10,
  parameter int unsigned EW = PW + 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 tick_i,
  input  logic                 fb_i,
  input  logic [PW-1:0]        cnt_i,
  input  logic [PW-1:0]        per_i,
  input  logic                 last_i,
  output logic signed [EW-1:0] err_o
);
  logic fb_s1, fb_s2, fb_prev, got_q, edge_w;
  logic [PW-1:0] half, centre;
  logic signed [EW-1:0] err_now, err_q;

  assign half    = per_i >> 1;
  assign centre  = half + ((per_i - half) >> 1);
  assign err_now = $signed(EW'(cnt_i)) - $signed(EW'(centre));
  assign edge_w  = tick_i && fb_s2 && !fb_prev;
  assign err_o   = got_q ? err_q : (edge_w ? err_now : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fb_s1   <= 1'b0;
      fb_s2   <= 1'b0;
      fb_prev <= 1'b0;
      got_q   <= 1'b0;
      err_q   <= '0;
    end else begin
      fb_s1 <= fb_i;
      fb_s2 <= fb_s1;
      if (tick_i) fb_prev <= fb_s2;
      if (last_i) begin
        got_q <= 1'b0;
      end else if (edge_w && !got_q) begin
        got_q <= 1'b1;
        err_q <= err_now;
      end
    end
  end

  // R6
  got_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(got_q) |-> $past(edge_w));
  // R6
  got_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_i |=> !got_q);
endmodule

// File: rtl/fb_loop_filter.sv
module fb_loop_filter
  import fbclk_pkg::*;
#(
  parameter int unsigned PW      = 10,
  parameter int unsigned EW      = PW + 2,
  parameter int unsigned KW      = 4,
  parameter int unsigned RST_PER = 240
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 last_i,
  input  logic signed [EW-1:0] err_i,
  input  logic [KW-1:0]        k_i,
  input  logic [PW-1:0]        min_i,
  input  logic [PW-1:0]        max_i,
  output logic [PW-1:0]        per_o,
  output logic [PW-1:0]        per_nxt_o
);
  localparam int unsigned YW = EW + FRAC_BITS;

  logic signed [YW-1:0] y_q, y_n;
  logic signed [YW:0]   diff, cand, c1, c2, c3;
  logic [PW-1:0]        per_q;

  always_comb begin
    diff = ((YW+1)'(err_i) <<< FRAC_BITS) - (YW+1)'(y_q);
    y_n  = y_q + YW'(diff >>> k_i);
    cand = (YW+1)'(RST_PER) + (YW+1)'(y_n >>> (FRAC_BITS + GAIN_SHR));
    c1   = (cand < $signed((YW+1)'(min_i))) ? $signed((YW+1)'(min_i)) : cand;
    c2   = (c1 > $signed((YW+1)'(max_i))) ? $signed((YW+1)'(max_i)) : c1;
    c3   = (c2 < $signed((YW+1)'(PER_FLOOR))) ? $signed((YW+1)'(PER_FLOOR)) : c2;
  end

  assign per_nxt_o = last_i ? PW'(c3) : per_q;
  assign per_o     = per_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      y_q   <= '0;
      per_q <= PW'(RST_PER);
    end else if (last_i) begin
      y_q   <= y_n;
      per_q <= PW'(c3);
    end
  end

  // R8
  per_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !last_i |=> $stable(per_q));
  // R8
  per_floor_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_q >= PW'(PER_FLOOR));
endmodule

// File: rtl/fb_clk_gen.sv
module fb_clk_gen #(
  parameter int unsigned PW      = 10,
  parameter int unsigned CW      = 8,
  parameter int unsigned KW      = 4,
  parameter int unsigned RST_PER = 240
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          fb_i,
  input  logic [KW-1:0] tc_shift_i,
  input  logic [PW-1:0] per_min_i,
  input  logic [PW-1:0] per_max_i,
  input  logic [CW-1:0] phase_i,
  input  logic [CW-1:0] duty_i,
  output logic          clk50_o,
  output logic          clk_ph_o,
  output logic [PW-1:0] period_o
);
  localparam int unsigned EW = PW + 2;

  logic tick_q, last_w;
  logic [PW-1:0] cnt_w, per_w, per_nxt_w;
  logic signed [EW-1:0] err_w;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tick_q <= 1'b0;
    else         tick_q <= !tick_q;
  end

  fb_clk_div #(.PW(PW), .CW(CW)) u_div (
    .clk_i, .rst_ni, .tick_i(tick_q), .per_i(per_w), .per_nxt_i(per_nxt_w),
    .phase_i, .duty_i, .cnt_o(cnt_w), .last_o(last_w), .clk50_o, .clk_ph_o
  );

  fb_phase_det #(.PW(PW), .EW(EW)) u_det (
    .clk_i, .rst_ni, .tick_i(tick_q), .fb_i, .cnt_i(cnt_w), .per_i(per_w),
    .last_i(last_w), .err_o(err_w)
  );

  fb_loop_filter #(.PW(PW), .EW(EW), .KW(KW), .RST_PER(RST_PER)) u_lf (
    .clk_i, .rst_ni, .last_i(last_w), .err_i(err_w), .k_i(tc_shift_i),
    .min_i(per_min_i), .max_i(per_max_i), .per_o(per_w), .per_nxt_o(per_nxt_w)
  );

  assign period_o = per_w;

  // R2
  tick_alt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_w |=> !last_w);
endmodule

// File: tb/sim_fb_clk_gen.sv
module sim_fb_clk_gen;
  logic clk = 1'b0, rst_ni = 1'b0, fb = 1'b0;
  logic [3:0] tc = 4'd2;
  logic [9:0] pmin = 10'd120, pmax = 10'd480;
  logic [7:0] ph = 8'd0, du = 8'd128;
  logic c50, cph;
  logic [9:0] per;

  fb_clk_gen u0 (.clk_i(clk), .rst_ni, .fb_i(fb), .tc_shift_i(tc), .per_min_i(pmin),
    .per_max_i(pmax), .phase_i(ph), .duty_i(du), .clk50_o(c50), .clk_ph_o(cph), .period_o(per));

  always #4 clk = !clk;

  int checks = 0, fails = 0;
  string req = "R1";

  // reference model
  int m_tick, m_s1, m_s2, m_prev, m_cnt, m_per, m_y, m_got, m_err, m_c50, m_cph;
  always @(posedge clk) begin
    if (!rst_ni) begin
      m_tick = 0; m_s1 = 0; m_s2 = 0; m_prev = 0; m_cnt = 0; m_per = 240;
      m_y = 0; m_got = 0; m_err = 0; m_c50 = 1; m_cph = 0;
    end else begin
      int t, edg, s2o, half, ctr, e, p, s, w, d;
      t = m_tick; s2o = m_s2;
      edg = t && m_s2 && !m_prev;
      m_tick = !m_tick; m_s2 = m_s1; m_s1 = fb;
      if (t) begin
        half = m_per / 2; ctr = half + (m_per - half) / 2;
        e = m_got ? m_err : (edg ? m_cnt - ctr : 0);
        if (edg && !m_got) begin m_got = 1; m_err = m_cnt - ctr; end
        if (m_cnt == m_per - 1) begin
          m_y = m_y + ((e * 256 - m_y) >>> tc);
          p = 240 + (m_y >>> 9);
          if (p < pmin) p = pmin;
          if (p > pmax) p = pmax;
          if (p < 4) p = 4;
          m_per = p; m_cnt = 0; m_got = 0;
        end else m_cnt++;
        m_prev = s2o;
      end
      m_c50 = m_cnt < m_per / 2;
      s = (ph * m_per) >> 8; w = (du * m_per) >> 8;
      d = (m_cnt >= s) ? m_cnt - s : m_cnt + m_per - s;
      m_cph = d < w;
    end
  end

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", r, act, exp, $time);
    end
  endtask

  // per-clock comparison
  logic cmp_en = 1'b0;
  always @(negedge clk) if (rst_ni && cmp_en) begin
    chk("R3", c50, m_c50);
    chk("R4", cph, m_cph);
    chk({"R5 R7 R8 ", req}, per, m_per);
  end

  // feedback generator
  int ext = 500, wid = 8, pc = 0;
  logic gen = 1'b0, chat = 1'b0;
  always @(negedge clk) begin
    if (!gen) begin pc <= 0; fb <= 1'b0; end
    else begin
      pc <= (pc + 1 >= ext) ? 0 : pc + 1;
      fb <= (pc < wid) || (chat && ((pc >= wid + 6 && pc < wid + 8) ||
                                    (pc >= wid + 14 && pc < wid + 16)));
    end
  end

  // R2 rise-to-rise measurement
  int rr = 0, last_rr = 0; logic c50_d = 1'b1;
  always @(negedge clk) begin
    c50_d <= c50;
    if (c50 && !c50_d) begin last_rr <= rr; rr <= 1; end else rr <= rr + 1;
  end

  int ph_hi = 0;
  always @(negedge clk) if (rst_ni) ph_hi <= ph_hi + int'(cph);

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #1_500_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    wait_clk(5);
    chk("R1 reset period", per, 240);
    chk("R1 reset clk50", c50, 1);
    chk("R1 reset clk_ph", cph, 0);
    rst_ni = 1'b1;
    #1;
    chk("R1 post-release period", per, 240);
    chk("R1 post-release clk50", c50, 1);
    wait_clk(1); cmp_en = 1'b1;
    req = "R9"; wait_clk(4000);
    chk("R2 clk50 period in clk_i cycles", last_rr, 480);
    chk("R9 idle period", per, 240);
    req = "R4"; ph = 8'd64; du = 8'd64; wait_clk(2000);
    req = "R7"; tc = 4'd3; ph = 8'd0; du = 8'd128; ext = 500; gen = 1'b1; wait_clk(30000);
    chk("R7 locked period vs model", per, m_per);
    req = "R8"; tc = 4'd1; pmin = 10'd200; pmax = 10'd260; ext = 300; wait_clk(20000);
    chk("R8 clamp low", int'(per >= 200), 1);
    chk("R8 clamp high", int'(per <= 260), 1);
    chk("R8 clamp vs model", per, m_per);
    req = "R6"; pmin = 10'd120; pmax = 10'd480; tc = 4'd4; ext = 460; chat = 1'b1;
    wait_clk(30000);
    chk("R6 chatter period vs model", per, m_per);
    chat = 1'b0;
    req = "R4"; du = 8'd0; ph = 8'd100; wait_clk(4); ph_hi = 0; wait_clk(2000);
    chk("R4 duty zero stays low", ph_hi, 0);
    ph = 8'd255; du = 8'd255; wait_clk(2000);
    req = "R8"; pmin = 10'd0; pmax = 10'd2; wait_clk(3000);
    chk("R8 floor of four", per, 4);
    chk("R2 floor period in clk_i cycles", last_rr, 8);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule